// File: doc/BRIEF.md
# Single-Cycle Integer Datapath

This block is the datapath half of a small single-cycle processor that handles
register add and subtract, OR with an unsigned immediate, word load, word store
and branch on equal. It holds the program counter, a 32-entry register file, an
immediate extender, an ALU, the operand and write-back selectors, and two
word-organised memory arrays, one for instructions and one for data. Every
instruction is fetched, executed and retired within a single clock.

The block does not decode anything. A separate control unit watches the opcode,
function and equality outputs and drives named select and enable inputs back
into it. Before a run, the program and any initial data are written into the
two arrays through a simple load port while reset is held. The PC, the ALU
result and the write-back value are brought out for observation.

Top module: `sc_datapath`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0 at the next rising edge; no register-file or data-memory write from the datapath occurs while `rst` is high.
- R2: With `npc_sel`=0 the PC advances by 4 at each rising edge.
- R3: With `npc_sel`=1 the PC becomes PC+4 plus the sign-extended 16-bit immediate (bits 15:0 of the instruction) shifted left by two; negative offsets branch backward.
- R4: The register file reads register rs (bits 25:21) as operand A and rt (bits 20:16) as operand B combinationally, and is written only at a rising edge with `reg_wr`=1; with `reg_wr`=0 no register changes.
- R5: Register 0 always reads as zero; writes to it are discarded.
- R6: `reg_dst`=0 writes to rt, `reg_dst`=1 writes to rd (bits 15:11).
- R7: `alu_src`=1 takes the extended immediate as operand B (`alu_src`=0 takes the rt register); `ext_sign`=0 zero-extends and `ext_sign`=1 sign-extends the immediate.
- R8: `alu_ctl` encodes 000 add, 001 subtract, 010 AND, 110 OR, 111 signed set-less-than giving 1 or 0 in bit 0.
- R9: `mem_wr`=1 stores operand B at the data word addressed by ALU result bits above 1 at the rising edge; `mem_to_reg`=1 selects the data-memory read word as write-back value, otherwise the ALU result.
- R10: `equal` is 1 exactly when the ALU result is zero, so with subtract and register operands it flags R[rs]==R[rt].
- R11: `opcode` shows instruction bits 31:26 and `funct` bits 5:0 of the word at the current PC.
- R12: With `load_en`=1 the word `load_data` is written at the rising edge to word `load_addr` of the instruction array (`load_to_imem`=1) or the data array (`load_to_imem`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the PC |
| load_en | input | 1 | Preload write strobe |
| load_to_imem | input | 1 | Preload target: 1 instruction array, 0 data array |
| load_addr | input | MA_W | Preload word index |
| load_data | input | 32 | Preload word |
| reg_dst | input | 1 | Destination select: 0 rt, 1 rd |
| alu_src | input | 1 | Operand B select: 0 register, 1 immediate |
| ext_sign | input | 1 | Immediate extension: 0 zero, 1 sign |
| alu_ctl | input | 3 | ALU operation code |
| mem_to_reg | input | 1 | Write-back select: 1 data memory, 0 ALU |
| mem_wr | input | 1 | Data memory write enable |
| reg_wr | input | 1 | Register file write enable |
| npc_sel | input | 1 | Next PC select: 0 sequential, 1 branch target |
| opcode | output | 6 | Opcode field of current instruction |
| funct | output | 6 | Function field of current instruction |
| equal | output | 1 | ALU result is zero |
| pc | output | 32 | Current program counter |
| alu_y | output | 32 | ALU result |
| wb_data | output | 32 | Value presented to the register write port |

## Verification
The hardest situation to reach is proving that a write did or did not land in a particular register, because the register file has no read port of its own at the boundary. The stimulus gets there by following each write with an add of that register to register 0 and comparing the ALU result, which exposes discarded writes to register 0, writes suppressed by a low enable, and the choice between rt and rd as destination. Branches are taken forward, not taken, and finally backward to address 0 so that both signs of the offset are exercised.

// File: rtl/sc_dp_pkg.sv
package sc_dp_pkg;

   localparam int WORD_W = 32;
   localparam int REG_CNT = 32;
   localparam int REG_AW = $clog2(REG_CNT);

   typedef enum logic [2:0] {
      ALU_ADD = 3'b000,
      ALU_SUB = 3'b001,
      ALU_AND = 3'b010,
      ALU_OR  = 3'b110,
      ALU_SLT = 3'b111
   } alu_ctl_e;

   typedef struct packed {
      logic [5:0]        op;
      logic [REG_AW-1:0] rs;
      logic [REG_AW-1:0] rt;
      logic [REG_AW-1:0] rd;
      logic [4:0]        shamt;
      logic [5:0]        fn;
   } instr_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile
   import sc_dp_pkg::*;
#(
   parameter int W = WORD_W,
   parameter int N = REG_CNT,
   parameter bit ZERO_REG = 1'b1,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ra,
   input  logic [AW-1:0] rb,
   input  logic [AW-1:0] wa,
   input  logic          we,
   input  logic [W-1:0]  wd,
   output logic [W-1:0]  rda,
   output logic [W-1:0]  rdb
);

   initial assert (N >= 2 && (1 << AW) == N)
      else $error("sc_regfile: N must be a power of two >= 2");

   logic [W-1:0] rf [N];

   always_ff @(posedge clk) begin
      if (we && !(ZERO_REG && wa == '0)) begin
         rf[wa] <= wd;
      end
   end

   generate
      if (ZERO_REG) begin : g_zero
         assign rda = (ra == '0) ? '0 : rf[ra];
         assign rdb = (rb == '0) ? '0 : rf[rb];
      end else begin : g_plain
         assign rda = rf[ra];
         assign rdb = rf[rb];
      end
   endgenerate

   // R4: without a write, a port whose select holds keeps its value
   a_r4_hold_a: assert property (@(posedge clk) disable iff (rst)
      !we |=> (ra != $past(ra)) || (rda == $past(rda)));
   a_r4_hold_b: assert property (@(posedge clk) disable iff (rst)
      !we |=> (rb != $past(rb)) || (rdb == $past(rdb)));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_dp_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic [2:0]   ctl,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   initial assert (W >= 2) else $error("sc_alu: W must be >= 2");

   always_comb begin
      case (alu_ctl_e'(ctl))
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
   end

   // R8: set-less-than drives only bit 0
   always_comb begin
      if (ctl == ALU_SLT) begin
         a_r8_slt_bit0: assert (y[W-1:1] == '0);
      end
   end

endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit
   import sc_dp_pkg::*;
#(
   parameter int W = WORD_W,
   parameter int IMM_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             npc_sel,
   input  logic [IMM_W-1:0] imm,
   output logic [W-1:0]     pc
);

   initial assert (W > IMM_W + 2) else $error("sc_pc_unit: W too small");

   logic [W-1:0] seq_pc;
   logic [W-1:0] br_off;

   assign seq_pc = pc + W'(4);
   assign br_off = {{(W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
      end else if (npc_sel) begin
         pc <= seq_pc + br_off;
      end else begin
         pc <= seq_pc;
      end
   end

   a_r1_pc_reset: assert property (@(posedge clk) rst |=> pc == '0);
   a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
      !npc_sel |=> pc == $past(pc) + W'(4));
   a_r3_branch: assert property (@(posedge clk) disable iff (rst)
      npc_sel |=> pc == $past(pc) + W'(4)
                      + {{(W-IMM_W-2){$past(imm[IMM_W-1])}}, $past(imm), 2'b00});

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
   import sc_dp_pkg::*;
#(
   parameter int MEM_WORDS = 64,
   parameter bit ZERO_REG = 1'b1,
   parameter int MA_W = $clog2(MEM_WORDS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load_en,
   input  logic            load_to_imem,
   input  logic [MA_W-1:0] load_addr,
   input  logic [31:0]     load_data,
   input  logic            reg_dst,
   input  logic            alu_src,
   input  logic            ext_sign,
   input  logic [2:0]      alu_ctl,
   input  logic            mem_to_reg,
   input  logic            mem_wr,
   input  logic            reg_wr,
   input  logic            npc_sel,
   output logic [5:0]      opcode,
   output logic [5:0]      funct,
   output logic            equal,
   output logic [31:0]     pc,
   output logic [31:0]     alu_y,
   output logic [31:0]     wb_data
);

   localparam int W = WORD_W;

   initial assert (MEM_WORDS >= 2 && (1 << MA_W) == MEM_WORDS)
      else $error("sc_datapath: MEM_WORDS must be a power of two >= 2");

   logic [W-1:0] imem [MEM_WORDS];
   logic [W-1:0] dmem [MEM_WORDS];

   instr_t       ins;
   logic [15:0]  imm16;
   logic [W-1:0] imm_ext;
   logic [W-1:0] bus_a;
   logic [W-1:0] bus_b;
   logic [W-1:0] opnd_b;
   logic [W-1:0] dm_rd;
   logic [REG_AW-1:0] dest;
   logic         rf_we;
   logic         dm_we;

   // fetch
   assign ins    = instr_t'(imem[pc[MA_W+1:2]]);
   assign imm16  = {ins.rd, ins.shamt, ins.fn};
   assign opcode = ins.op;
   assign funct  = ins.fn;

   sc_pc_unit #(.W(W), .IMM_W(16)) u_pc (
      .clk     (clk),
      .rst     (rst),
      .npc_sel (npc_sel),
      .imm     (imm16),
      .pc      (pc)
   );

   // operands
   assign dest    = reg_dst ? ins.rd : ins.rt;
   assign rf_we   = reg_wr && !rst;
   assign imm_ext = ext_sign ? {{(W-16){imm16[15]}}, imm16} : {{(W-16){1'b0}}, imm16};
   assign opnd_b  = alu_src ? imm_ext : bus_b;

   sc_regfile #(.W(W), .N(REG_CNT), .ZERO_REG(ZERO_REG)) u_rf (
      .clk (clk),
      .rst (rst),
      .ra  (ins.rs),
      .rb  (ins.rt),
      .wa  (dest),
      .we  (rf_we),
      .wd  (wb_data),
      .rda (bus_a),
      .rdb (bus_b)
   );

   sc_alu #(.W(W)) u_alu (
      .ctl (alu_ctl),
      .a   (bus_a),
      .b   (opnd_b),
      .y   (alu_y)
   );

   assign equal = (alu_y == '0);

   // memories and write-back
   assign dm_we   = mem_wr && !rst;
   assign dm_rd   = dmem[alu_y[MA_W+1:2]];
   assign wb_data = mem_to_reg ? dm_rd : alu_y;

   always_ff @(posedge clk) begin
      if (load_en && load_to_imem) begin
         imem[load_addr] <= load_data;
      end
   end

   always_ff @(posedge clk) begin
      if (load_en && !load_to_imem) begin
         dmem[load_addr] <= load_data;
      end else if (dm_we) begin
         dmem[alu_y[MA_W+1:2]] <= bus_b;
      end
   end

   // R10: subtracting register operands flags equality of the two read ports
   a_r10_equal: assert property (@(posedge clk) disable iff (rst)
      (alu_ctl == ALU_SUB && !alu_src) |-> (equal == (bus_a == bus_b)));

endmodule

// File: tb/tb_sc_datapath.sv
module tb_sc_datapath;

   localparam int CLK_PERIOD = 10;
   localparam int MA_W = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load_en = 1'b0;
   logic load_to_imem = 1'b0;
   logic [MA_W-1:0] load_addr = '0;
   logic [31:0] load_data = '0;
   logic reg_dst = 0, alu_src = 0, ext_sign = 0, mem_to_reg = 0;
   logic mem_wr = 0, reg_wr = 0, npc_sel = 0;
   logic [2:0] alu_ctl = 3'b000;
   logic [5:0] opcode, funct;
   logic equal;
   logic [31:0] pc, alu_y, wb_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [2:0] C_ADD = 3'b000, C_SUB = 3'b001, C_AND = 3'b010,
                          C_OR = 3'b110, C_SLT = 3'b111;

   sc_datapath #(.MEM_WORDS(64)) dut (
      .clk(clk), .rst(rst), .load_en(load_en), .load_to_imem(load_to_imem),
      .load_addr(load_addr), .load_data(load_data), .reg_dst(reg_dst),
      .alu_src(alu_src), .ext_sign(ext_sign), .alu_ctl(alu_ctl),
      .mem_to_reg(mem_to_reg), .mem_wr(mem_wr), .reg_wr(reg_wr),
      .npc_sel(npc_sel), .opcode(opcode), .funct(funct), .equal(equal),
      .pc(pc), .alu_y(alu_y), .wb_data(wb_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load_word(bit to_imem, int idx, logic [31:0] w);
      @(negedge clk);
      load_en = 1; load_to_imem = to_imem; load_addr = MA_W'(idx); load_data = w;
      @(posedge clk); #1;
      load_en = 0;
   endtask

   // drive controls for the current instruction, then settle
   task automatic exec(logic rd_s, logic as, logic es, logic [2:0] op,
                       logic m2r, logic mw, logic rw, logic ns);
      @(negedge clk);
      reg_dst = rd_s; alu_src = as; ext_sign = es; alu_ctl = op;
      mem_to_reg = m2r; mem_wr = mw; reg_wr = rw; npc_sel = ns;
      #1;
   endtask

   task automatic adv();
      @(posedge clk); #1;
   endtask

   task automatic t_load_program();
      load_word(1, 0,  itype(6'h0d, 0, 1, 16'h8005));
      load_word(1, 1,  itype(6'h09, 0, 2, 16'hFFFC));
      load_word(1, 2,  rtype(1, 2, 3, 6'h21));
      load_word(1, 3,  rtype(1, 2, 4, 6'h23));
      load_word(1, 4,  rtype(1, 2, 5, 6'h24));
      load_word(1, 5,  rtype(2, 1, 6, 6'h2a));
      load_word(1, 6,  rtype(1, 2, 7, 6'h2a));
      load_word(1, 7,  rtype(3, 0, 12, 6'h21));
      load_word(1, 8,  rtype(2, 0, 13, 6'h21));
      load_word(1, 9,  itype(6'h2b, 0, 1, 16'h0008));
      load_word(1, 10, itype(6'h23, 0, 8, 16'h0008));
      load_word(1, 11, itype(6'h0d, 0, 0, 16'hFFFF));
      load_word(1, 12, rtype(0, 0, 9, 6'h21));
      load_word(1, 13, itype(6'h0d, 0, 1, 16'h7777));
      load_word(1, 14, rtype(1, 0, 10, 6'h21));
      load_word(1, 15, rtype(8, 0, 11, 6'h21));
      load_word(1, 16, itype(6'h23, 0, 14, 16'h0014));
      load_word(1, 17, itype(6'h04, 1, 8, 16'd3));
      load_word(1, 21, itype(6'h04, 1, 2, 16'd5));
      load_word(1, 22, itype(6'h04, 0, 0, 16'hFFE9));
      load_word(0, 5,  32'hCAFE_F00D);
   endtask

   task automatic t_reset();
      chk("R1 pc in reset", pc, 32'h0);
      chk("R12 preloaded opcode", {26'd0, opcode}, 32'h0d);
   endtask

   task automatic t_immediates();
      rst = 0;
      exec(0, 1, 0, C_OR, 0, 0, 1, 0);
      chk("R11 opcode", {26'd0, opcode}, 32'h0d);
      chk("R7 zero extend", alu_y, 32'h0000_8005);
      adv();
      chk("R2 pc step", pc, 32'd4);
      exec(0, 1, 1, C_ADD, 0, 0, 1, 0);
      chk("R7 sign extend", alu_y, 32'hFFFF_FFFC);
      adv();
   endtask

   task automatic t_alu_rr();
      exec(1, 0, 0, C_ADD, 0, 0, 1, 0);
      chk("R11 funct", {26'd0, funct}, 32'h21);
      chk("R8 add", alu_y, 32'h0000_8001);
      adv();
      exec(1, 0, 0, C_SUB, 0, 0, 1, 0);
      chk("R8 sub", alu_y, 32'h0000_8009);
      adv();
      exec(1, 0, 0, C_AND, 0, 0, 1, 0);
      chk("R8 and", alu_y, 32'h0000_8004);
      adv();
      exec(1, 0, 0, C_SLT, 0, 0, 1, 0);
      chk("R8 slt true", alu_y, 32'd1);
      adv();
      exec(1, 0, 0, C_SLT, 0, 0, 1, 0);
      chk("R8 slt false", alu_y, 32'd0);
      adv();
      exec(1, 0, 0, C_ADD, 0, 0, 0, 0);
      chk("R6 rd destination written", alu_y, 32'h0000_8001);
      adv();
      exec(1, 0, 0, C_ADD, 0, 0, 0, 0);
      chk("R6 rt untouched by rd write", alu_y, 32'hFFFF_FFFC);
      adv();
   endtask

   task automatic t_memory();
      exec(0, 1, 1, C_ADD, 0, 1, 0, 0);
      chk("R9 store address", alu_y, 32'd8);
      adv();
      exec(0, 1, 1, C_ADD, 1, 0, 1, 0);
      chk("R9 load data", wb_data, 32'h0000_8005);
      adv();
   endtask

   task automatic t_reg_write();
      exec(0, 1, 0, C_OR, 0, 0, 1, 0);
      adv();
      exec(1, 0, 0, C_ADD, 0, 0, 0, 0);
      chk("R5 r0 reads zero", alu_y, 32'd0);
      adv();
      exec(0, 1, 0, C_OR, 0, 0, 0, 0);
      adv();
      exec(1, 0, 0, C_ADD, 0, 0, 0, 0);
      chk("R4 no write when disabled", alu_y, 32'h0000_8005);
      adv();
      exec(1, 0, 0, C_ADD, 0, 0, 0, 0);
      chk("R9 loaded register", alu_y, 32'h0000_8005);
      adv();
      exec(0, 1, 1, C_ADD, 1, 0, 1, 0);
      chk("R12 preloaded data word", wb_data, 32'hCAFE_F00D);
      adv();
   endtask

   task automatic t_branch();
      chk("R2 pc before branch", pc, 32'd68);
      exec(0, 0, 1, C_SUB, 0, 0, 0, 1);
      chk("R10 equal set", {31'd0, equal}, 32'd1);
      adv();
      chk("R3 forward target", pc, 32'd84);
      exec(0, 0, 1, C_SUB, 0, 0, 0, 0);
      chk("R10 equal clear", {31'd0, equal}, 32'd0);
      adv();
      chk("R2 not taken", pc, 32'd88);
      exec(0, 0, 1, C_SUB, 0, 0, 0, 1);
      adv();
      chk("R3 backward target", pc, 32'd0);
   endtask

   task automatic t_reset_mid();
      exec(0, 1, 0, C_OR, 0, 0, 1, 0);
      adv();
      chk("R2 pc after restart", pc, 32'd4);
      exec(0, 0, 0, C_ADD, 0, 0, 0, 0);
      rst = 1;
      adv();
      chk("R1 pc reset mid-run", pc, 32'd0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      t_load_program();
      t_reset();
      t_immediates();
      t_alu_rr();
      t_memory();
      t_reg_write();
      t_branch();
      t_reset_mid();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule